// File: doc/BRIEF.md
# Extended Load/Store Address Generator

This block sits between a decoder and a data memory port in a 64-bit integer core. It accepts one decoded memory operation at a time, forms the effective address, drives a single valid/ready request channel, sign- or zero-extends the returned load data, and raises register write-back strobes when the operation finishes. It handles three addressing modes. The first adds a scaled register index to the base, with an option to use only the zero-extended low 32 bits of the index. The second steps the base by a scaled immediate, addresses before or after the step, and writes the new base back. The third moves two consecutive items with one operation.

Before any memory traffic, a legality check runs on the operation. Register overlaps that would leave the result undefined are rejected, as are paired accesses of unsupported size and 64-bit-only forms issued in 32-bit mode. A rejected operation pulses an illegal flag for one cycle. It does not touch memory and does not write any register. Operations are accepted only while `busy` is low.

Top module: `memx_agu`

## Requirements
- R1: With `op_mode`=0 (indexed), the single access address is `base_val + (index_val << op_scale)`, where `op_scale` is 0 to 3.
- R2: With `op_mode`=1 (unsigned index), only `index_val[31:0]` is used. It is zero-extended to 64 bits and then shifted left by `op_scale` before the add.
- R3: With `op_mode`=2 (base update), the step is `op_imm5`, read as a 5-bit two's-complement value, sign-extended and shifted left by `op_scale`. When `op_pre`=1 the access uses base+step, otherwise it uses base. Loads and stores both write base+step to register `op_rs1` through `base_we`.
- R4: A base-update load with `op_rd` equal to `op_rs1` is illegal.
- R5: With `op_mode`=3 (pair), the first item is at base + (`op_pimm` << 4) for doublewords or base + (`op_pimm` << 3) for words. The second item is at that address plus 8 or 4. Stores send `wdata_a` and then `wdata_b`. Loads write item one to `op_rd` and item two to `op_rd2`.
- R6: A pair operation is illegal if its size is byte or halfword. A pair load is also illegal if `op_rs1` equals `op_rd` or `op_rd2`, or if `op_rd` equals `op_rd2`.
- R7: `op_size` selects byte (0), halfword (1), word (2) or doubleword (3). Load data arrives in the low bits of `mem_rdata`. It is sign-extended when `op_unsigned`=0 and zero-extended when `op_unsigned`=1.
- R8: When `xlen64`=0, doubleword accesses and unsigned word loads are illegal.
- R9: A pair issues its second beat only after the first beat's handshake. `done` pulses once, one cycle after the last beat's handshake, together with the write-back strobes. `busy` is high from acceptance until `done` or `illegal`.
- R10: An illegal operation pulses `illegal` for exactly one cycle, the cycle after acceptance. It produces no memory request and no write strobe.
- R11: While `mem_req` is high and `mem_ready` is low, the request's address, direction and data are held until the handshake.
- R12: All address sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present; taken when busy is low |
| op_mode | input | 2 | 0 indexed, 1 unsigned index, 2 base update, 3 pair |
| op_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| op_store | input | 1 | 1 store, 0 load |
| op_unsigned | input | 1 | Zero-extend load data |
| op_pre | input | 1 | Base update: address after the step |
| op_scale | input | 2 | Shift amount for index or step |
| op_imm5 | input | 5 | Signed step immediate |
| op_pimm | input | 2 | Pair offset immediate |
| op_rd | input | 5 | Destination (or first pair destination) |
| op_rd2 | input | 5 | Second pair destination |
| op_rs1 | input | 5 | Base register number |
| xlen64 | input | 1 | 64-bit mode |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| wdata_a | input | 64 | Store data, first item |
| wdata_b | input | 64 | Store data, second item |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | Request size code |
| mem_addr | output | 64 | Request address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory accepts / completes request |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| done | output | 1 | Operation complete pulse |
| illegal | output | 1 | Rejected operation pulse |
| rf_we1 | output | 1 | Write first load result |
| rf_waddr1 | output | 5 | First destination |
| rf_wdata1 | output | 64 | First load result |
| rf_we2 | output | 1 | Write second pair result |
| rf_waddr2 | output | 5 | Second destination |
| rf_wdata2 | output | 64 | Second pair result |
| base_we | output | 1 | Write updated base |
| base_waddr | output | 5 | Base register number |
| base_wdata | output | 64 | Updated base value |

## Verification
Some properties are checked on every cycle by assertions. A stalled request must hold its address and direction. A rejected operation must pulse only once, with no request before it and no write strobe. Completion must follow a handshake. Write strobes must never target two equal registers. The arithmetic itself cannot be seen by those properties, so only the bench scenarios show it. That covers scaled and zero-extended indices, every signed step with both step orders, pair offsets and item spacing, wraparound, and extension for each size. It also covers which operand overlaps and mode restrictions are rejected.

// File: rtl/memx_agu_pkg.sv
package memx_agu_pkg;
  typedef enum logic [1:0] {
    AM_INDEX  = 2'd0,
    AM_INDEXU = 2'd1,
    AM_STEP   = 2'd2,
    AM_PAIR   = 2'd3
  } am_mode_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BEAT1 = 3'd1,
    ST_BEAT2 = 3'd2,
    ST_FIN   = 3'd3,
    ST_ERR   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/memx_agu_addr.sv
module memx_agu_addr
  import memx_agu_pkg::*;
#(
  parameter int XW = 64
) (
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  input  logic          pre,
  input  logic [1:0]    scale,
  input  logic [4:0]    imm5,
  input  logic [1:0]    pimm,
  input  logic [XW-1:0] base,
  input  logic [XW-1:0] index,
  output logic [XW-1:0] addr_a,
  output logic [XW-1:0] addr_b,
  output logic [XW-1:0] base_upd
);
  localparam int HALF = XW / 2;

  logic [XW-1:0] idx_src;
  logic [XW-1:0] idx_off;
  logic [XW-1:0] step;
  logic [XW-1:0] pair_off;
  logic [XW-1:0] item_bytes;
  logic [XW-1:0] pair_a;

  always_comb begin
    idx_src    = (am_mode_e'(mode) == AM_INDEXU) ? {{HALF{1'b0}}, index[HALF-1:0]} : index;
    idx_off    = idx_src << scale;
    step       = {{(XW-5){imm5[4]}}, imm5} << scale;
    pair_off   = (acc_size_e'(size) == SZ_D) ? (XW'(pimm) << 4) : (XW'(pimm) << 3);
    item_bytes = (acc_size_e'(size) == SZ_D) ? XW'(8) : XW'(4);
    pair_a     = base + pair_off;
    base_upd   = base + step;
    case (am_mode_e'(mode))
      AM_INDEX, AM_INDEXU: begin
        addr_a = base + idx_off;
        addr_b = base + idx_off;
      end
      AM_STEP: begin
        addr_a = pre ? base_upd : base;
        addr_b = pre ? base_upd : base;
      end
      default: begin
        addr_a = pair_a;
        addr_b = pair_a + item_bytes;
      end
    endcase
  end
endmodule

// File: rtl/memx_agu_legal.sv
module memx_agu_legal
  import memx_agu_pkg::*;
#(
  parameter int RIW = 5
) (
  input  logic [1:0]     mode,
  input  logic [1:0]     size,
  input  logic           store,
  input  logic           uns,
  input  logic           xlen64,
  input  logic [RIW-1:0] rd,
  input  logic [RIW-1:0] rd2,
  input  logic [RIW-1:0] rs1,
  output logic           bad
);
  logic wide_bad;
  logic step_bad;
  logic pair_bad;

  always_comb begin
    wide_bad = !xlen64 && ((acc_size_e'(size) == SZ_D) ||
                           (acc_size_e'(size) == SZ_W && uns && !store));
    step_bad = (am_mode_e'(mode) == AM_STEP) && !store && (rd == rs1);
    pair_bad = 1'b0;
    if (am_mode_e'(mode) == AM_PAIR) begin
      if (acc_size_e'(size) == SZ_B || acc_size_e'(size) == SZ_H) pair_bad = 1'b1;
      if (!store && ((rs1 == rd) || (rs1 == rd2) || (rd == rd2))) pair_bad = 1'b1;
    end
    bad = wide_bad || step_bad || pair_bad;
  end
endmodule

// File: rtl/memx_agu_ext.sv
module memx_agu_ext
  import memx_agu_pkg::*;
#(
  parameter int XW = 64
) (
  input  logic [1:0]    size,
  input  logic          uns,
  input  logic [XW-1:0] raw,
  output logic [XW-1:0] val
);
  localparam int NNARROW = 3;

  logic [XW-1:0] cand [NNARROW];

  for (genvar g = 0; g < NNARROW; g++) begin : g_narrow
    localparam int W = 8 << g;
    assign cand[g] = uns ? {{(XW-W){1'b0}}, raw[W-1:0]}
                         : {{(XW-W){raw[W-1]}}, raw[W-1:0]};
  end

  always_comb begin
    case (acc_size_e'(size))
      SZ_B:    val = cand[0];
      SZ_H:    val = cand[1];
      SZ_W:    val = cand[2];
      default: val = raw;
    endcase
  end
endmodule

// File: rtl/memx_agu.sv
module memx_agu
  import memx_agu_pkg::*;
#(
  parameter int XW  = 64,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [1:0]     op_mode,
  input  logic [1:0]     op_size,
  input  logic           op_store,
  input  logic           op_unsigned,
  input  logic           op_pre,
  input  logic [1:0]     op_scale,
  input  logic [4:0]     op_imm5,
  input  logic [1:0]     op_pimm,
  input  logic [RIW-1:0] op_rd,
  input  logic [RIW-1:0] op_rd2,
  input  logic [RIW-1:0] op_rs1,
  input  logic           xlen64,
  input  logic [XW-1:0]  base_val,
  input  logic [XW-1:0]  index_val,
  input  logic [XW-1:0]  wdata_a,
  input  logic [XW-1:0]  wdata_b,
  output logic           busy,
  output logic           mem_req,
  output logic           mem_we,
  output logic [1:0]     mem_size,
  output logic [XW-1:0]  mem_addr,
  output logic [XW-1:0]  mem_wdata,
  input  logic           mem_ready,
  input  logic [XW-1:0]  mem_rdata,
  output logic           done,
  output logic           illegal,
  output logic           rf_we1,
  output logic [RIW-1:0] rf_waddr1,
  output logic [XW-1:0]  rf_wdata1,
  output logic           rf_we2,
  output logic [RIW-1:0] rf_waddr2,
  output logic [XW-1:0]  rf_wdata2,
  output logic           base_we,
  output logic [RIW-1:0] base_waddr,
  output logic [XW-1:0]  base_wdata
);
  seq_state_e    state_q, state_d;

  logic [XW-1:0] a_addr_a, a_addr_b, a_base_upd;
  logic          op_bad;
  logic          accept;
  logic          take1, take2;
  logic [XW-1:0] ext_val;

  logic [1:0]     c_mode, c_size;
  logic           c_store, c_uns;
  logic [RIW-1:0] c_rd, c_rd2, c_rs1;
  logic [XW-1:0]  c_addr_a, c_addr_b, c_base_upd, c_wd1, c_wd2;
  logic [XW-1:0]  d1_q, d2_q;

  memx_agu_addr #(.XW(XW)) u_addr (
    .mode     (op_mode),
    .size     (op_size),
    .pre      (op_pre),
    .scale    (op_scale),
    .imm5     (op_imm5),
    .pimm     (op_pimm),
    .base     (base_val),
    .index    (index_val),
    .addr_a   (a_addr_a),
    .addr_b   (a_addr_b),
    .base_upd (a_base_upd)
  );

  memx_agu_legal #(.RIW(RIW)) u_legal (
    .mode   (op_mode),
    .size   (op_size),
    .store  (op_store),
    .uns    (op_unsigned),
    .xlen64 (xlen64),
    .rd     (op_rd),
    .rd2    (op_rd2),
    .rs1    (op_rs1),
    .bad    (op_bad)
  );

  memx_agu_ext #(.XW(XW)) u_ext (
    .size (c_size),
    .uns  (c_uns),
    .raw  (mem_rdata),
    .val  (ext_val)
  );

  // control: next state
  always_comb begin
    accept  = (state_q == ST_IDLE) && op_valid;
    take1   = (state_q == ST_BEAT1) && mem_ready;
    take2   = (state_q == ST_BEAT2) && mem_ready;
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (op_valid) state_d = op_bad ? ST_ERR : ST_BEAT1;
      ST_BEAT1: if (mem_ready) state_d = (am_mode_e'(c_mode) == AM_PAIR) ? ST_BEAT2 : ST_FIN;
      ST_BEAT2: if (mem_ready) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      ST_ERR:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // operation context, loaded on accept
  always_ff @(posedge clk) begin
    if (accept) begin
      c_mode     <= op_mode;
      c_size     <= op_size;
      c_store    <= op_store;
      c_uns      <= op_unsigned;
      c_rd       <= op_rd;
      c_rd2      <= op_rd2;
      c_rs1      <= op_rs1;
      c_addr_a   <= a_addr_a;
      c_addr_b   <= a_addr_b;
      c_base_upd <= a_base_upd;
      c_wd1      <= wdata_a;
      c_wd2      <= wdata_b;
    end
  end

  // load result holding registers
  always_ff @(posedge clk) begin
    if (take1) d1_q <= ext_val;
    if (take2) d2_q <= ext_val;
  end

  // outputs
  always_comb begin
    busy       = (state_q != ST_IDLE);
    mem_req    = (state_q == ST_BEAT1) || (state_q == ST_BEAT2);
    mem_we     = c_store;
    mem_size   = c_size;
    mem_addr   = (state_q == ST_BEAT2) ? c_addr_b : c_addr_a;
    mem_wdata  = (state_q == ST_BEAT2) ? c_wd2 : c_wd1;
    done       = (state_q == ST_FIN);
    illegal    = (state_q == ST_ERR);
    rf_we1     = done && !c_store;
    rf_we2     = done && !c_store && (am_mode_e'(c_mode) == AM_PAIR);
    base_we    = done && (am_mode_e'(c_mode) == AM_STEP);
    rf_waddr1  = c_rd;
    rf_waddr2  = c_rd2;
    base_waddr = c_rs1;
    rf_wdata1  = d1_q;
    rf_wdata2  = d2_q;
    base_wdata = c_base_upd;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req && !rf_we1 && !rf_we2 && !base_we && !$past(mem_req)); // R10
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ready)); // R9
  AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we2 |-> rf_we1 && (rf_waddr1 != rf_waddr2) && !base_we); // R6
  AST_STEP_NO_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    base_we && rf_we1 |-> base_waddr != rf_waddr1); // R4
endmodule

// File: tb/memx_agu_bench.sv
module memx_agu_bench;
  localparam int CLK_PER = 10;

  logic        clk, rst_n;
  logic        op_valid, op_store, op_unsigned, op_pre, xlen64;
  logic [1:0]  op_mode, op_size, op_scale, op_pimm;
  logic [4:0]  op_imm5, op_rd, op_rd2, op_rs1;
  logic [63:0] base_val, index_val, wdata_a, wdata_b;
  logic        busy, mem_req, mem_we, mem_ready, done, illegal;
  logic [1:0]  mem_size;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        rf_we1, rf_we2, base_we;
  logic [4:0]  rf_waddr1, rf_waddr2, base_waddr;
  logic [63:0] rf_wdata1, rf_wdata2, base_wdata;

  memx_agu u_memx_agu (.*);

  int tests = 0, fails = 0;
  int lat = 0, wc = 0;
  int nlog = 0;
  bit saw_we = 0;
  logic [63:0] lg_addr [4];
  logic [63:0] lg_wd   [4];
  logic        lg_we   [4];
  logic [1:0]  lg_sz   [4];
  bit g_done, g_ill;
  logic        k_we1, k_we2, k_bwe;
  logic [4:0]  k_wa1, k_wa2, k_bwa;
  logic [63:0] k_wd1, k_wd2, k_bwd;

  function automatic logic [63:0] mdl(input logic [63:0] a);
    return {a[31:0] ^ 32'h8C3F0E71, ~a[31:0] ^ 32'h13579BDF};
  endfunction

  function automatic logic [63:0] ext(input int sz, input bit u, input logic [63:0] v);
    case (sz)
      0: return u ? {56'd0, v[7:0]}  : {{56{v[7]}}, v[7:0]};
      1: return u ? {48'd0, v[15:0]} : {{48{v[15]}}, v[15:0]};
      2: return u ? {32'd0, v[31:0]} : {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  assign mem_ready = mem_req && (wc >= lat);
  assign mem_rdata = mdl(mem_addr);

  initial clk = 0;
  always #(CLK_PER/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wc <= wc + 1;
    else wc <= 0;
  end

  always @(negedge clk) begin
    if (rf_we1 || rf_we2 || base_we) saw_we = 1;
    if (mem_req && mem_ready && nlog < 4) begin
      lg_addr[nlog] = mem_addr;
      lg_wd[nlog]   = mem_wdata;
      lg_we[nlog]   = mem_we;
      lg_sz[nlog]   = mem_size;
      nlog++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int mode, input int sz, input bit st, input bit u, input bit pre,
                        input int sc, input int imm, input int pim, input int rd, input int rd2,
                        input int rs1, input bit x64, input logic [63:0] b, input logic [63:0] ix);
    @(negedge clk);
    op_mode = 2'(mode); op_size = 2'(sz); op_store = st; op_unsigned = u; op_pre = pre;
    op_scale = 2'(sc); op_imm5 = 5'(imm); op_pimm = 2'(pim); op_rd = 5'(rd); op_rd2 = 5'(rd2);
    op_rs1 = 5'(rs1); xlen64 = x64; base_val = b; index_val = ix;
    wdata_a = {b[31:0], ix[31:0]} ^ 64'h0F0F_1234_5678_9ABC;
    wdata_b = ~wdata_a;
    op_valid = 1; nlog = 0; saw_we = 0; g_done = 0; g_ill = 0;
    lat = (lat + 1) % 3;
    @(negedge clk);
    op_valid = 0;
    for (int i = 0; i < 20; i++) begin
      if (done || illegal) break;
      @(negedge clk);
    end
    g_done = done; g_ill = illegal;
    k_we1 = rf_we1; k_we2 = rf_we2; k_bwe = base_we;
    k_wa1 = rf_waddr1; k_wa2 = rf_waddr2; k_bwa = base_waddr;
    k_wd1 = rf_wdata1; k_wd2 = rf_wdata2; k_bwd = base_wdata;
  endtask

  // checks a legal single-beat access at address a
  task automatic chk_single(input string tag, input int sz, input bit st, input bit u,
                            input int rd, input logic [63:0] a);
    chk({tag, " done"}, {63'd0, g_done}, 64'd1);
    chk({tag, " beats"}, 64'(nlog), 64'd1);
    chk({tag, " addr"}, lg_addr[0], a);
    chk({tag, " dir/size"}, {61'd0, lg_we[0], lg_sz[0]}, {61'd0, st, 2'(sz)});
    if (st) begin
      chk({tag, " wdata"}, lg_wd[0], wdata_a);
      chk({tag, " no rf write"}, {63'd0, k_we1}, 64'd0);
    end else begin
      chk({tag, " rf we"}, {58'd0, k_we1, k_wa1}, {58'd0, 1'b1, 5'(rd)});
      chk({tag, " R7 data"}, k_wd1, ext(sz, u, mdl(a)));
    end
  endtask

  task automatic chk_illegal(input string tag);
    chk({tag, " R10 flag"}, {62'd0, g_ill, g_done}, 64'd2);
    chk({tag, " R10 no access"}, 64'(nlog), 64'd0);
    chk({tag, " R10 no write"}, {63'd0, saw_we}, 64'd0);
  endtask

  initial begin
    op_valid = 0; op_mode = 0; op_size = 0; op_store = 0; op_unsigned = 0; op_pre = 0;
    op_scale = 0; op_imm5 = 0; op_pimm = 0; op_rd = 0; op_rd2 = 0; op_rs1 = 0; xlen64 = 1;
    base_val = 0; index_val = 0; wdata_a = 0; wdata_b = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset busy/req/done/illegal", {60'd0, busy, mem_req, done, illegal}, 64'd0);
    rst_n = 1;

    // R1 / R2: indexed sweep
    for (int m = 0; m < 2; m++)
      for (int sc = 0; sc < 4; sc++)
        for (int sz = 0; sz < 4; sz++)
          for (int v = 0; v < 4; v++) begin
            logic [63:0] b, ix, src, a;
            b  = 64'h1000_0000_0000_0100;
            ix = (v[0]) ? 64'hFFFF_FFFF_8000_0010 : 64'h0000_0003_0000_0044;
            src = (m == 1) ? {32'd0, ix[31:0]} : ix;
            a = b + (src << sc);
            run_op(m, sz, v[1], v[0], 0, sc, 0, 0, 7, 0, 3, 1, b, ix);
            chk_single((m == 1) ? "R2 idxu" : "R1 idx", sz, v[1], v[0], 7, a);
          end

    // R12: wraparound
    run_op(0, 3, 0, 0, 0, 1, 0, 0, 9, 0, 2, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20);
    chk_single("R12 wrap", 3, 0, 0, 9, 64'h30);

    // R3: base update sweep over every immediate, scale and order
    for (int imm = 0; imm < 32; imm++)
      for (int sc = 0; sc < 4; sc++)
        for (int pre = 0; pre < 2; pre++) begin
          logic [63:0] b, step, a;
          b = 64'h0000_2000_0000_0800;
          step = {{59{imm[4]}}, imm[4:0]} << sc;
          a = pre ? b + step : b;
          run_op(2, 2, imm[0], 0, pre[0], sc, imm, 0, 5, 0, 6, 1, b, 64'hDEAD);
          chk_single("R3 step", 2, imm[0], 0, 5, a);
          chk("R3 base write", {58'd0, k_bwe, k_bwa}, {58'd0, 1'b1, 5'd6});
          chk("R3 base value", k_bwd, b + step);
        end

    // R4: base-update load onto its own base is rejected; store is fine
    run_op(2, 2, 0, 0, 1, 1, 3, 0, 6, 0, 6, 1, 64'h100, 0);
    chk_illegal("R4 load rd==base");
    run_op(2, 2, 1, 0, 1, 1, 3, 0, 6, 0, 6, 1, 64'h100, 0);
    chk_single("R4 store rd==base legal", 2, 1, 0, 6, 64'h106);

    // R5 / R9: pair sweep
    for (int d = 0; d < 2; d++)
      for (int pim = 0; pim < 4; pim++)
        for (int v = 0; v < 4; v++) begin
          logic [63:0] b, a0, a1;
          int sz;
          sz = d ? 3 : 2;
          b = 64'h0000_0004_0000_1000;
          a0 = b + (64'(pim) << (d ? 4 : 3));
          a1 = a0 + (d ? 64'd8 : 64'd4);
          run_op(3, sz, v[1], v[0], 0, 0, 0, pim, 10, 11, 12, 1, b, 0);
          chk("R9 pair done", {63'd0, g_done}, 64'd1);
          chk("R9 pair beats", 64'(nlog), 64'd2);
          chk("R5 pair addr0", lg_addr[0], a0);
          chk("R5 pair addr1", lg_addr[1], a1);
          if (v[1]) begin
            chk("R5 pair wdata0", lg_wd[0], wdata_a);
            chk("R5 pair wdata1", lg_wd[1], wdata_b);
            chk("R5 pair store no write", {62'd0, k_we1, k_we2}, 64'd0);
          end else begin
            chk("R5 pair we", {52'd0, k_we1, k_wa1, k_we2, k_wa2}, {52'd0, 1'b1, 5'd10, 1'b1, 5'd11});
            chk("R7 pair data0", k_wd1, ext(sz, v[0], mdl(a0)));
            chk("R7 pair data1", k_wd2, ext(sz, v[0], mdl(a1)));
          end
        end

    // R6: pair overlap and size rejections
    run_op(3, 3, 0, 0, 0, 0, 0, 1, 4, 8, 4, 1, 64'h200, 0);
    chk_illegal("R6 base==rd");
    run_op(3, 3, 0, 0, 0, 0, 0, 1, 4, 8, 8, 1, 64'h200, 0);
    chk_illegal("R6 base==rd2");
    run_op(3, 2, 0, 0, 0, 0, 0, 1, 9, 9, 4, 1, 64'h200, 0);
    chk_illegal("R6 rd==rd2");
    run_op(3, 1, 1, 0, 0, 0, 0, 1, 9, 10, 4, 1, 64'h200, 0);
    chk_illegal("R6 half pair");

    // R8: 32-bit mode restrictions
    run_op(0, 3, 0, 0, 0, 0, 0, 0, 1, 0, 2, 0, 64'h300, 8);
    chk_illegal("R8 double in 32-bit");
    run_op(0, 2, 0, 1, 0, 0, 0, 0, 1, 0, 2, 0, 64'h300, 8);
    chk_illegal("R8 unsigned word load in 32-bit");
    run_op(0, 2, 0, 0, 0, 0, 0, 0, 1, 0, 2, 0, 64'h300, 8);
    chk_single("R8 signed word in 32-bit", 2, 0, 0, 1, 64'h308);
    run_op(0, 2, 1, 1, 0, 0, 0, 0, 1, 0, 2, 0, 64'h300, 8);
    chk_single("R8 word store in 32-bit", 2, 1, 1, 1, 64'h308);

    // R11: request held while stalled
    @(negedge clk);
    lat = 2;
    op_mode = 0; op_size = 3; op_store = 1; op_scale = 0; base_val = 64'h4440; index_val = 8;
    xlen64 = 1; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
    chk("R11 stall first cycle", {63'd0, mem_req && !mem_ready}, 64'd1);
    chk("R9 busy while active", {63'd0, busy}, 64'd1);
    @(negedge clk);
    chk("R11 stall hold addr", mem_addr, 64'h4448);
    @(negedge clk);
    chk("R11 handshake addr", {mem_addr[62:0], mem_ready}, {63'h4448, 1'b1});
    @(negedge clk);
    chk("R9 done after handshake", {63'd0, done}, 64'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    fails++; tests++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule